// File: doc/BRIEF.md
# Page-Buffered Write Sequencer

This block models the write path of a byte-wide non-volatile memory whose array is written one whole page at a time. A host writes bytes over a bus that has an active-low select, an active-low write strobe and an active-low output enable. Each accepted strobe puts one byte into a 128-byte page buffer. The first byte opens a load phase. Every later byte must carry the same page number and keeps the phase open. When no new strobe arrives within a programmable number of clock cycles, the block leaves the load phase and enters a timed programming phase. During that phase it reports busy. At the end of the phase it writes the whole page into a synchronous array model in a single cycle. Any buffer slot that was not loaded is written as the erased value FFh.

The bus pins are sampled on the block clock. A byte load is recognised in the cycle when the combined write strobe ends. All time limits are parameters counted in clock cycles. The array model keeps 2^ARRAY_PAGE_AW pages and has a one-cycle read port, so the committed contents can be observed. The block also reports the address and data of the most recent byte load it recognised.

Top module: `page_write_seq`

## Requirements
- R1: Address bits 16..7 are the page number and bits 6..0 are the byte index within the page. The array model holds 2^ARRAY_PAGE_AW pages (8 by default), selected by the low ARRAY_PAGE_AW bits of the page number. `peek_addr` is {page[ARRAY_PAGE_AW-1:0], byte[6:0]}.
- R2: A strobe is active only while `chip_sel_n`=0, `wr_strobe_n`=0 and `out_en_n`=1. A byte is recognised when the strobe ends because `chip_sel_n` or `wr_strobe_n` returns high while `out_en_n` is still 1. If `out_en_n` falls during the strobe, or only one of the two strobes is low, no byte is recognised.
- R3: The address is taken in the first active cycle of a strobe. The data is taken in the last active cycle.
- R4: Programming begins exactly LOAD_TIMEOUT cycles after the clock edge that recognised the last byte. Any active strobe restarts this count, so a new strobe that becomes active within the window keeps the load phase open.
- R5: Bytes may be loaded in any order. A second load to the same byte within one phase replaces the earlier value.
- R6: `busy` is high for exactly PROG_CYCLES cycles. The page is committed at the edge where `busy` falls. `peek_data` shows the array byte at `peek_addr` one cycle after that address is sampled.
- R7: A commit writes all 128 bytes of the page. Bytes not loaded in the phase become FFh, and other pages are unchanged.
- R8: Strobes while `busy` is high are ignored. `last_addr` and `last_data` keep their values, no array contents change, and no new load phase opens.
- R9: A byte whose page number differs from that of the open phase aborts the phase. Nothing is committed and `busy` stays low.
- R10: After reset, `busy`=0, `last_addr`=0, `last_data`=0 and every array byte reads FFh. `last_addr` and `last_data` follow each recognised byte load.
- R11: Every new load phase starts with an empty buffer. Bytes loaded in an earlier phase are not carried over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_sel_n | input | 1 | Active-low device select |
| wr_strobe_n | input | 1 | Active-low write strobe |
| out_en_n | input | 1 | Active-low output enable; low inhibits writes |
| bus_addr | input | 17 | Byte address: page number and byte index |
| bus_wdata | input | 8 | Write data |
| peek_addr | input | 10 | Array read address {page, byte} |
| busy | output | 1 | High during internal programming |
| last_addr | output | 17 | Address of the most recent recognised byte load |
| last_data | output | 8 | Data of the most recent recognised byte load |
| peek_data | output | 8 | Registered array read data |

## Verification
Several load patterns are used. An out-of-order partial page shows that the byte index selects the slot and that empty slots are filled with FFh. A repeated write to one slot tests which value wins. A strobe whose address and data change partway through shows which cycle supplies each one. A second byte placed at the last cycle that still keeps the phase open, set against the exact cycle count of an expiring phase, pins the timeout boundary. Strobes with the output enable low, strobes during busy, and a byte to a foreign page must all leave the array and `busy` unchanged. A reload of an earlier page shows that the buffer was cleared.

// File: rtl/pbw_pkg.sv
package pbw_pkg;
    localparam int ADDR_W     = 17;
    localparam int DATA_W     = 8;
    localparam int BYTE_AW    = 7;
    localparam int PAGE_BYTES = 1 << BYTE_AW;
    localparam int PAGE_AW    = ADDR_W - BYTE_AW;
    localparam int ROW_W      = PAGE_BYTES * DATA_W;

    typedef logic [ADDR_W-1:0]  addr_t;
    typedef logic [DATA_W-1:0]  data_t;
    typedef logic [BYTE_AW-1:0] byte_idx_t;
    typedef logic [PAGE_AW-1:0] page_t;
    typedef logic [ROW_W-1:0]   row_t;

    localparam data_t ERASED = '1;

    typedef struct packed {
        addr_t addr;
        data_t data;
    } load_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_PROG
    } phase_t;

    function automatic page_t page_of(addr_t a);
        return a[ADDR_W-1:BYTE_AW];
    endfunction

    function automatic byte_idx_t byte_of(addr_t a);
        return a[BYTE_AW-1:0];
    endfunction
endpackage

// File: rtl/pbw_strobe.sv
module pbw_strobe
    import pbw_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  chip_sel_n,
    input  logic  wr_strobe_n,
    input  logic  out_en_n,
    input  logic  busy,
    input  addr_t bus_addr,
    input  data_t bus_wdata,
    output logic  strobe_on,
    output logic  ld_valid,
    output load_t ld
);
    logic  act, act_q, cap_ok;
    addr_t cap_addr;
    data_t cap_data;

    assign act = !chip_sel_n && !wr_strobe_n && out_en_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q    <= 1'b0;
            cap_ok   <= 1'b0;
            cap_addr <= '0;
            cap_data <= '0;
        end else begin
            act_q <= act;
            if (act && !act_q) begin
                cap_addr <= bus_addr;
                cap_ok   <= !busy;
            end
            if (act) begin
                cap_data <= bus_wdata;
            end
        end
    end

    assign strobe_on = act;
    assign ld_valid  = act_q && !act && out_en_n && cap_ok && !busy;
    assign ld        = '{addr: cap_addr, data: cap_data};

    // R2
    load_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        ld_valid |-> $past(!chip_sel_n && !wr_strobe_n && out_en_n));

    // R2
    load_needs_oe_high_chk: assert property (@(posedge clk) disable iff (rst)
        !out_en_n |-> !ld_valid);
endmodule

// File: rtl/pbw_page_buf.sv
module pbw_page_buf
    import pbw_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr,
    input  logic      clear,
    input  byte_idx_t idx,
    input  data_t     wdata,
    output row_t      row
);
    logic [PAGE_BYTES-1:0]             vld_q;
    logic [PAGE_BYTES-1:0][DATA_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= '0;
            data_q <= '0;
        end else if (wr) begin
            vld_q       <= (clear ? '0 : vld_q) | (PAGE_BYTES'(1) << idx);
            data_q[idx] <= wdata;
        end
    end

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_merge
        assign row[g*DATA_W +: DATA_W] = vld_q[g] ? data_q[g] : ERASED;
    end

    // R11
    fresh_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && clear) |=> ($countones(vld_q) == 1));

    // R5
    slot_marked_chk: assert property (@(posedge clk) disable iff (rst)
        wr |=> vld_q[$past(idx)]);
endmodule

// File: rtl/pbw_array.sv
module pbw_array
    import pbw_pkg::*;
#(
    parameter int PAGES_AW = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                commit,
    input  logic [PAGES_AW-1:0] cpage,
    input  row_t                crow,
    input  logic [PAGES_AW-1:0] rd_page,
    input  byte_idx_t           rd_byte,
    output data_t               rd_data
);
    localparam int NPAGES = 1 << PAGES_AW;

    row_t mem_q [NPAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NPAGES; i++) begin
                mem_q[i] <= '1;
            end
            rd_data <= ERASED;
        end else begin
            if (commit) begin
                mem_q[cpage] <= crow;
            end
            rd_data <= mem_q[rd_page][rd_byte*DATA_W +: DATA_W];
        end
    end
endmodule

// File: rtl/pbw_ctrl.sv
module pbw_ctrl
    import pbw_pkg::*;
#(
    parameter int LOAD_TIMEOUT = 16,
    parameter int PROG_CYCLES  = 24
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  strobe_on,
    input  logic  ld_valid,
    input  load_t ld,
    output logic  busy,
    output logic  buf_wr,
    output logic  buf_clear,
    output logic  commit,
    output page_t page_q,
    output addr_t last_addr,
    output data_t last_data
);
    localparam int TW = $clog2(LOAD_TIMEOUT + 1);
    localparam int PW = $clog2(PROG_CYCLES + 1);

    phase_t        state_q;
    logic [TW-1:0] tmr_q;
    logic [PW-1:0] pcnt_q;
    logic          same_page;

    assign same_page = page_of(ld.addr) == page_q;
    assign buf_clear = ld_valid && (state_q == ST_IDLE);
    assign buf_wr    = ld_valid && ((state_q == ST_IDLE) ||
                                    ((state_q == ST_LOAD) && same_page));
    assign busy      = state_q == ST_PROG;
    assign commit    = busy && (pcnt_q == PW'(PROG_CYCLES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            tmr_q     <= '0;
            pcnt_q    <= '0;
            page_q    <= '0;
            last_addr <= '0;
            last_data <= '0;
        end else begin
            if (ld_valid) begin
                last_addr <= ld.addr;
                last_data <= ld.data;
            end
            case (state_q)
                ST_IDLE: begin
                    if (ld_valid) begin
                        state_q <= ST_LOAD;
                        page_q  <= page_of(ld.addr);
                        tmr_q   <= '0;
                    end
                end
                ST_LOAD: begin
                    if (ld_valid) begin
                        if (same_page) begin
                            tmr_q <= '0;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end else if (strobe_on) begin
                        tmr_q <= '0;
                    end else if (tmr_q == TW'(LOAD_TIMEOUT - 1)) begin
                        state_q <= ST_PROG;
                        pcnt_q  <= '0;
                    end else begin
                        tmr_q <= tmr_q + TW'(1);
                    end
                end
                ST_PROG: begin
                    if (commit) begin
                        state_q <= ST_IDLE;
                    end else begin
                        pcnt_q <= pcnt_q + PW'(1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R4
    no_prog_mid_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_LOAD) && strobe_on) |=> !busy);

    // R6
    commit_ends_busy_chk: assert property (@(posedge clk) disable iff (rst)
        commit |=> !busy);

    // R6
    prog_bounded_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (pcnt_q < PW'(PROG_CYCLES)));

    // R8
    busy_keeps_last_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(last_addr) && $stable(last_data)));

    // R9
    foreign_page_abort_chk: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_LOAD) && ld_valid && !same_page) |=> (!busy && !commit));
endmodule

// File: rtl/page_write_seq.sv
module page_write_seq
    import pbw_pkg::*;
#(
    parameter int LOAD_TIMEOUT  = 16,
    parameter int PROG_CYCLES   = 24,
    parameter int ARRAY_PAGE_AW = 3,
    localparam int PEEK_W       = BYTE_AW + ARRAY_PAGE_AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chip_sel_n,
    input  logic              wr_strobe_n,
    input  logic              out_en_n,
    input  logic [16:0]       bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic [PEEK_W-1:0] peek_addr,
    output logic              busy,
    output logic [16:0]       last_addr,
    output logic [7:0]        last_data,
    output logic [7:0]        peek_data
);
    logic  strobe_on, ld_valid, buf_wr, buf_clear, commit;
    load_t ld;
    page_t page_q;
    row_t  row;

    pbw_strobe u_strobe (
        .clk         (clk),
        .rst         (rst),
        .chip_sel_n  (chip_sel_n),
        .wr_strobe_n (wr_strobe_n),
        .out_en_n    (out_en_n),
        .busy        (busy),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .strobe_on   (strobe_on),
        .ld_valid    (ld_valid),
        .ld          (ld)
    );

    pbw_ctrl #(
        .LOAD_TIMEOUT (LOAD_TIMEOUT),
        .PROG_CYCLES  (PROG_CYCLES)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .strobe_on (strobe_on),
        .ld_valid  (ld_valid),
        .ld        (ld),
        .busy      (busy),
        .buf_wr    (buf_wr),
        .buf_clear (buf_clear),
        .commit    (commit),
        .page_q    (page_q),
        .last_addr (last_addr),
        .last_data (last_data)
    );

    pbw_page_buf u_buf (
        .clk   (clk),
        .rst   (rst),
        .wr    (buf_wr),
        .clear (buf_clear),
        .idx   (byte_of(ld.addr)),
        .wdata (ld.data),
        .row   (row)
    );

    pbw_array #(
        .PAGES_AW (ARRAY_PAGE_AW)
    ) u_array (
        .clk     (clk),
        .rst     (rst),
        .commit  (commit),
        .cpage   (page_q[ARRAY_PAGE_AW-1:0]),
        .crow    (row),
        .rd_page (peek_addr[PEEK_W-1:BYTE_AW]),
        .rd_byte (peek_addr[BYTE_AW-1:0]),
        .rd_data (peek_data)
    );
endmodule

// File: tb/test_page_write_seq.sv
module test_page_write_seq;
    localparam int T = 16;
    localparam int P = 24;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1, wr_n = 1'b1, oe_n = 1'b1;
    logic [16:0] addr = '0;
    logic [7:0]  wd = '0;
    logic [9:0]  rda = '0;
    logic        busy;
    logic [16:0] la;
    logic [7:0]  ldat, rdd;
    int          checks = 0, errors = 0;

    always #10 clk = ~clk;

    page_write_seq #(.LOAD_TIMEOUT(T), .PROG_CYCLES(P)) i_page_write_seq (
        .clk(clk), .rst(rst), .chip_sel_n(cs_n), .wr_strobe_n(wr_n),
        .out_en_n(oe_n), .bus_addr(addr), .bus_wdata(wd), .peek_addr(rda),
        .busy(busy), .last_addr(la), .last_data(ldat), .peek_data(rdd));

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_byte(logic [16:0] a, logic [7:0] d);
        @(negedge clk); addr = a; wd = d; cs_n = 0; wr_n = 0;
        @(negedge clk);
        @(negedge clk); wr_n = 1; cs_n = 1;
    endtask

    task automatic read_chk(string req, int a, logic [7:0] exp);
        @(negedge clk); rda = 10'(a);
        @(negedge clk); chk(req, rdd, exp);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // must follow the last wr_byte directly
    task automatic wait_commit(string req);
        repeat (T) @(negedge clk);
        chk({req, " busy before timeout"}, busy, 0);
        @(negedge clk);
        chk({req, " busy at timeout"}, busy, 1);
        repeat (P-1) @(negedge clk);
        chk({req, " busy last prog cycle"}, busy, 1);
        @(negedge clk);
        chk({req, " busy after commit"}, busy, 0);
    endtask

    task automatic watch_quiet(string req, int n);
        int seen = 0;
        repeat (n) begin
            @(negedge clk);
            if (busy) seen = 1;
        end
        chk(req, seen, 0);
    endtask

    task automatic t_reset();
        chk("R10 busy reset", busy, 0);
        chk("R10 last_addr reset", la, 0);
        chk("R10 last_data reset", ldat, 0);
        read_chk("R10 array erased", 0, 8'hFF);
    endtask

    task automatic t_page_basic();
        wr_byte(17'd261, 8'hA5);
        wr_byte(17'd256, 8'h11);
        wr_byte(17'd383, 8'h7E);
        wait_commit("R4 R6");
        chk("R10 last_addr", la, 383);
        chk("R10 last_data", ldat, 8'h7E);
        read_chk("R1 byte 5", 261, 8'hA5);
        read_chk("R5 byte 0", 256, 8'h11);
        read_chk("R1 byte 127", 383, 8'h7E);
        read_chk("R7 unloaded", 300, 8'hFF);
        read_chk("R7 other page", 389, 8'hFF);
    endtask

    task automatic t_override();
        wr_byte(17'd393, 8'h22);
        wr_byte(17'd393, 8'h33);
        wr_byte(17'd385, 8'h44);
        wait_commit("R6 override");
        read_chk("R5 replaced", 393, 8'h33);
        read_chk("R5 second", 385, 8'h44);
    endtask

    task automatic t_keepalive();
        wr_byte(17'd130, 8'h5A);
        idle(T-1);
        chk("R4 window open", busy, 0);
        wr_byte(17'd131, 8'h6B);
        wait_commit("R4 extended");
        read_chk("R4 first", 130, 8'h5A);
        read_chk("R4 second", 131, 8'h6B);
    endtask

    task automatic t_inhibit();
        @(negedge clk); addr = 17'd770; wd = 8'hE1; cs_n = 0; wr_n = 0;
        @(negedge clk);
        @(negedge clk); oe_n = 0;
        @(negedge clk); cs_n = 1; wr_n = 1; oe_n = 1;
        @(negedge clk); addr = 17'd771; cs_n = 0;
        idle(3);
        @(negedge clk); cs_n = 1;
        chk("R2 last_addr kept", la, 131);
        watch_quiet("R2 no phase", T+P+4);
        read_chk("R2 array kept", 770, 8'hFF);
        read_chk("R2 array kept sel", 771, 8'hFF);
    endtask

    task automatic t_capture();
        @(negedge clk); addr = 17'd647; wd = 8'h3C; cs_n = 0; wr_n = 0;
        @(negedge clk); addr = 17'd648; wd = 8'hC3;
        @(negedge clk); wr_n = 1; cs_n = 1;
        wait_commit("R3");
        chk("R3 first addr", la, 647);
        chk("R3 last data", ldat, 8'hC3);
        read_chk("R3 stored", 647, 8'hC3);
        read_chk("R3 not at late addr", 648, 8'hFF);
    endtask

    task automatic t_busy_ignore();
        wr_byte(17'd10, 8'h99);
        repeat (T+1) @(negedge clk);
        chk("R8 busy", busy, 1);
        wr_byte(17'd769, 8'h77);
        idle(P);
        chk("R8 done", busy, 0);
        chk("R8 last_addr kept", la, 10);
        chk("R8 last_data kept", ldat, 8'h99);
        watch_quiet("R8 no phase", T+4);
        read_chk("R8 ignored page", 769, 8'hFF);
        read_chk("R8 committed", 10, 8'h99);
    endtask

    task automatic t_abort();
        wr_byte(17'd513, 8'h12);
        wr_byte(17'd641, 8'h34);
        watch_quiet("R9 no prog", T+P+4);
        read_chk("R9 first page", 513, 8'hFF);
        read_chk("R9 foreign page", 641, 8'hFF);
        read_chk("R9 old data kept", 647, 8'hC3);
    endtask

    task automatic t_newphase();
        wr_byte(17'd320, 8'h55);
        wait_commit("R11");
        read_chk("R11 old byte 5 gone", 261, 8'hFF);
        read_chk("R11 old byte 0 gone", 256, 8'hFF);
        read_chk("R11 new byte", 320, 8'h55);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_page_basic();
        t_override();
        t_keepalive();
        t_inhibit();
        t_capture();
        t_busy_ignore();
        t_abort();
        t_newphase();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual running expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule